// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects event pulses from a set of interrupt sources and presents one request at a time to a small 8-bit CPU core, together with the address the core should branch to. Each source has a sticky flag, an enable bit and a priority bit. A pair of global enable bits decides which qualified sources may actually reach the core. The CPU answers with an acknowledge pulse when it takes the interrupt and with a return pulse when the handler finishes. The controller keeps track of which levels are currently being serviced.

The controller runs in one of two modes. In legacy mode the priority bits do nothing and every request uses one vector. Enable bit 0 gates all sources, and enable bit 1 additionally gates the upper group of peripheral sources. In priority mode enable bit 0 is the high-level enable and enable bit 1 is the low-level enable. High-priority sources use vector 0x0008 and low-priority sources use 0x0018. A high-level request may preempt a low-level handler. Source events cross two synchronizer stages, so an external event reaches the core a fixed few cycles later.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The vector output is 0x0008 for a high-level request and 0x0018 for a low-level request. In legacy mode (mode bit 0) every request is high level with vector 0x0008, whatever the priority bits hold.
- R2: After reset all flags, enables, priority bits and both global enable bits are 0, the mode is legacy, no level is in service and no request is raised.
- R3: In legacy mode a source with index below NUM_CORE requests when its flag and enable are set and global bit 0 is set. A source at or above NUM_CORE also needs global bit 1.
- R4: In priority mode a source whose priority bit is 1 requests when its flag and enable are set and global bit 0 is set. With global bit 0 clear, no source requests at all.
- R5: In priority mode a source whose priority bit is 0 requests only when global bits 0 and 1 are both set and no high level is in service (in-service bit 0 clear).
- R6: A flag is set by its synchronized event whatever the enables hold, and it stays set until a clear strobe for that source. An event and a clear that arrive in the same cycle leave the flag set.
- R7: An acknowledge while the request is raised clears global bit 0 and sets in-service bit 0 for a high-level take. For a low-level take it clears global bit 1 and sets in-service bit 1. The request drops on that same edge.
- R8: A return pulse ends the highest level in service. If in-service bit 0 is set, it clears that bit and sets global bit 0. Otherwise, if in-service bit 1 is set, it clears that bit and sets global bit 1.
- R9: While a low-level handler is in service, a qualified high-level source raises a request at vector 0x0008.
- R10: An event pulse sampled at clock edge k, on an enabled source that is otherwise allowed through, raises the request at edge k+3.
- R11: High level wins over low level. Within the delivered level, the lowest-numbered qualified source is reported on the source output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | NUM_SRC | Source event pulses, one per source |
| flag_clr_i | input | NUM_SRC | Software clear strobes for the flags |
| en_we_i | input | 1 | Write strobe for the enable bits |
| en_wdata_i | input | NUM_SRC | New enable bits |
| pri_we_i | input | 1 | Write strobe for the priority bits (1 = high) |
| pri_wdata_i | input | NUM_SRC | New priority bits |
| gen_we_i | input | 1 | Write strobe for the global enables |
| gen_wdata_i | input | 2 | New global enables (bit 0 high/all, bit 1 low/peripheral) |
| mode_we_i | input | 1 | Write strobe for the mode bit |
| mode_wdata_i | input | 1 | New mode (0 legacy, 1 priority) |
| ack_i | input | 1 | CPU takes the presented interrupt |
| rfi_i | input | 1 | CPU returns from an interrupt handler |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 16 | Branch address for the request |
| irq_src_o | output | $clog2(NUM_SRC) | Lowest qualified source index at the delivered level |
| irq_high_o | output | 1 | 1 when the request is high level |
| flag_o | output | NUM_SRC | Current flags |
| gen_o | output | 2 | Current global enables |
| mode_o | output | 1 | Current mode |
| insvc_o | output | 2 | In service (bit 0 high, bit 1 low) |

## Verification
Nesting is the main target. The bench takes a low-level interrupt, lets a high-level one preempt it, and then returns twice. A controller that unwinds the wrong level first would re-enable low requests while the high handler still runs, and a low request would show up too early. Low-priority events raised during a high handler, even after software turns both enables back on, must stay silent. The same holds for priority bits in legacy mode. A design that ignored the in-service state, or honoured priority in legacy mode, would give a request or a 0x0018 vector. An event and a clear are made to arrive together to catch a flag that loses the event. The request is timed from the event edge to catch an extra or a missing pipeline stage.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam logic [15:0] VEC_HIGH = 16'h0008;
  localparam logic [15:0] VEC_LOW  = 16'h0018;
  // global enable and in-service bit positions
  localparam int G_HI = 0;
  localparam int G_LO = 1;
  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;
endpackage

// File: rtl/ictl_sync.sv
module ictl_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ictl_src_regs.sv
module ictl_src_regs #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_s_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wd_i,
  input  logic         pri_we_i,
  input  logic [N-1:0] pri_wd_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pri_o
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] en_q, en_d;
  logic [N-1:0] pri_q, pri_d;

  always_comb begin
    // an arriving event outranks a clear in the same cycle
    flag_d = (flag_q & ~clr_i) | evt_s_i;
    en_d   = en_we_i  ? en_wd_i  : en_q;
    pri_d  = pri_we_i ? pri_wd_i : pri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      pri_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_we_i)  en_q  <= en_d;
      if (pri_we_i) pri_q <= pri_d;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign pri_o  = pri_q;

  // R6: a set flag only falls under its clear strobe
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q & ~clr_i) & ~flag_q) == '0));

  // R6: a synchronized event always lands in its flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_s_i != '0) |=> ((flag_q & $past(evt_s_i)) == $past(evt_s_i)));
endmodule

// File: rtl/ictl_select.sv
module ictl_select #(
  parameter int N     = 8,
  parameter int NCORE = 4,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  flag_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  pri_i,
  input  logic [1:0]    gen_i,
  input  logic          mode_i,
  input  logic [1:0]    insvc_i,
  output logic          req_o,
  output logic          req_high_o,
  output logic [IW-1:0] req_src_o
);
  import ictl_pkg::*;

  logic [N-1:0] core_mask;
  for (genvar i = 0; i < N; i++) begin : g_mask
    assign core_mask[i] = (i < NCORE);
  end

  logic [N-1:0] pend, leg_v, hi_v, lo_v, pick_v;
  logic [IW-1:0] first_idx;

  always_comb begin
    pend  = flag_i & en_i;
    leg_v = pend & (core_mask | {N{gen_i[G_LO]}}) & {N{gen_i[G_HI]}};
    hi_v  = pend & pri_i & {N{gen_i[G_HI]}};
    lo_v  = pend & ~pri_i &
            {N{gen_i[G_HI] & gen_i[G_LO] & ~insvc_i[G_HI]}};
    if (!mode_i) begin
      pick_v     = leg_v;
      req_high_o = 1'b1;
    end else if (|hi_v) begin
      pick_v     = hi_v;
      req_high_o = 1'b1;
    end else begin
      pick_v     = lo_v;
      req_high_o = 1'b0;
    end
    req_o = |pick_v;
  end

  always_comb begin
    first_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pick_v[i]) first_idx = IW'(i);
    end
  end

  assign req_src_o = first_idx;
endmodule

// File: rtl/ictl_ctrl.sv
module ictl_ctrl #(
  parameter int N   = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_high_i,
  input  logic [IW-1:0] req_src_i,
  input  logic          ack_i,
  input  logic          rfi_i,
  input  logic          gen_we_i,
  input  logic [1:0]    gen_wd_i,
  input  logic          mode_we_i,
  input  logic          mode_wd_i,
  output logic [1:0]    gen_o,
  output logic          mode_o,
  output logic [1:0]    insvc_o,
  output logic          irq_o,
  output logic [15:0]   vec_o,
  output logic [IW-1:0] src_o,
  output logic          high_o
);
  import ictl_pkg::*;

  logic [1:0]    gen_q, gen_d;
  logic [1:0]    insvc_q, insvc_d;
  logic          mode_q, mode_d;
  logic          irq_q, irq_d;
  logic [15:0]   vec_q, vec_d;
  logic [IW-1:0] src_q, src_d;
  logic          high_q, high_d;
  logic          take;

  assign take = ack_i & irq_q;

  always_comb begin
    gen_d   = gen_q;
    insvc_d = insvc_q;
    if (take) begin
      if (high_q) begin
        gen_d[G_HI]   = 1'b0;
        insvc_d[G_HI] = 1'b1;
      end else begin
        gen_d[G_LO]   = 1'b0;
        insvc_d[G_LO] = 1'b1;
      end
    end else if (rfi_i) begin
      if (insvc_q[G_HI]) begin
        insvc_d[G_HI] = 1'b0;
        gen_d[G_HI]   = 1'b1;
      end else if (insvc_q[G_LO]) begin
        insvc_d[G_LO] = 1'b0;
        gen_d[G_LO]   = 1'b1;
      end
    end
    if (gen_we_i) gen_d = gen_wd_i;
    mode_d = mode_we_i ? mode_wd_i : mode_q;
    irq_d  = req_i & ~take;
    high_d = req_high_i;
    vec_d  = irq_d ? (req_high_i ? VEC_HIGH : VEC_LOW) : 16'h0000;
    src_d  = irq_d ? req_src_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= '0;
      insvc_q <= '0;
      mode_q  <= 1'b0;
      irq_q   <= 1'b0;
      vec_q   <= '0;
      src_q   <= '0;
      high_q  <= 1'b0;
    end else begin
      gen_q   <= gen_d;
      insvc_q <= insvc_d;
      if (mode_we_i) mode_q <= mode_d;
      irq_q   <= irq_d;
      vec_q   <= vec_d;
      src_q   <= src_d;
      high_q  <= high_d;
    end
  end

  assign gen_o   = gen_q;
  assign mode_o  = mode_q;
  assign insvc_o = insvc_q;
  assign irq_o   = irq_q;
  assign vec_o   = vec_q;
  assign src_o   = src_q;
  assign high_o  = high_q;

  // R5: no low-level request while a high handler runs
  p_low_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !high_q) |-> !insvc_q[G_HI]);

  // R1: legacy mode only ever presents the high level
  p_legacy_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(mode_q)) |-> high_q);

  // R7: a take closes its level and drops the request
  p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_q && !gen_we_i) |=>
      (!irq_q && ($past(high_q) ? (!gen_q[G_HI] && insvc_q[G_HI])
                               : (!gen_q[G_LO] && insvc_q[G_LO]))));

  // R8: a return ends the high level first when it is active
  p_rfi_high_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi_i && !(ack_i && irq_q) && !gen_we_i && insvc_q[G_HI]) |=>
      (gen_q[G_HI] && !insvc_q[G_HI] && (insvc_q[G_LO] == $past(insvc_q[G_LO]))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC     = 8,
  parameter int NUM_CORE    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               pri_we_i,
  input  logic [NUM_SRC-1:0] pri_wdata_i,
  input  logic               gen_we_i,
  input  logic [1:0]         gen_wdata_i,
  input  logic               mode_we_i,
  input  logic               mode_wdata_i,
  input  logic               ack_i,
  input  logic               rfi_i,
  output logic               irq_o,
  output logic [15:0]        irq_vec_o,
  output logic [IW-1:0]      irq_src_o,
  output logic               irq_high_o,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [1:0]         gen_o,
  output logic               mode_o,
  output logic [1:0]         insvc_o
);
  logic [NUM_SRC-1:0] evt_s, flag, en, pri;
  logic               req, req_high;
  logic [IW-1:0]      req_src;

  ictl_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(evt_i), .q_o(evt_s)
  );

  ictl_src_regs #(.N(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .evt_s_i(evt_s), .clr_i(flag_clr_i),
    .en_we_i(en_we_i), .en_wd_i(en_wdata_i),
    .pri_we_i(pri_we_i), .pri_wd_i(pri_wdata_i),
    .flag_o(flag), .en_o(en), .pri_o(pri)
  );

  ictl_select #(.N(NUM_SRC), .NCORE(NUM_CORE)) u_sel (
    .flag_i(flag), .en_i(en), .pri_i(pri), .gen_i(gen_o),
    .mode_i(mode_o), .insvc_i(insvc_o),
    .req_o(req), .req_high_o(req_high), .req_src_o(req_src)
  );

  ictl_ctrl #(.N(NUM_SRC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_high_i(req_high),
    .req_src_i(req_src), .ack_i(ack_i), .rfi_i(rfi_i),
    .gen_we_i(gen_we_i), .gen_wd_i(gen_wdata_i),
    .mode_we_i(mode_we_i), .mode_wd_i(mode_wdata_i),
    .gen_o(gen_o), .mode_o(mode_o), .insvc_o(insvc_o),
    .irq_o(irq_o), .vec_o(irq_vec_o), .src_o(irq_src_o), .high_o(irq_high_o)
  );

  assign flag_o = flag;
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int N  = 8;
  localparam int NC = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, flag_clr_i = '0, en_wdata_i = '0, pri_wdata_i = '0;
  logic en_we_i = 1'b0, pri_we_i = 1'b0, gen_we_i = 1'b0, mode_we_i = 1'b0;
  logic mode_wdata_i = 1'b0, ack_i = 1'b0, rfi_i = 1'b0;
  logic [1:0] gen_wdata_i = '0;
  logic irq_o, irq_high_o, mode_o;
  logic [15:0] irq_vec_o;
  logic [IW-1:0] irq_src_o;
  logic [N-1:0] flag_o;
  logic [1:0] gen_o, insvc_o;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .NUM_CORE(NC), .SYNC_STAGES(2)) u_irq_prio_ctrl (
    .clk, .rst_n, .evt_i, .flag_clr_i, .en_we_i, .en_wdata_i, .pri_we_i,
    .pri_wdata_i, .gen_we_i, .gen_wdata_i, .mode_we_i, .mode_wdata_i,
    .ack_i, .rfi_i, .irq_o, .irq_vec_o, .irq_src_o, .irq_high_o, .flag_o,
    .gen_o, .mode_o, .insvc_o
  );

  // behavioural reference model, advanced on every rising edge
  bit m_s1 [N], m_s2 [N], m_flag [N], m_en [N], m_pri [N];
  bit m_ghi, m_glo, m_mode, m_shi, m_slo, m_irq, m_high;
  int m_src, m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_flag[i] = 0; m_en[i] = 0; m_pri[i] = 0;
      end
      m_ghi = 0; m_glo = 0; m_mode = 0; m_shi = 0; m_slo = 0;
      m_irq = 0; m_high = 0; m_src = 0; m_vec = 0;
    end else begin
      bit found, lvl, take;
      int who;
      found = 0; lvl = 1; who = 0;
      if (!m_mode) begin
        for (int i = 0; i < N; i++)
          if (!found && m_flag[i] && m_en[i] && m_ghi && (i < NC || m_glo)) begin
            found = 1; who = i;
          end
      end else begin
        for (int i = 0; i < N; i++)
          if (!found && m_flag[i] && m_en[i] && m_pri[i] && m_ghi) begin
            found = 1; who = i;
          end
        if (!found) begin
          lvl = 0;
          for (int i = 0; i < N; i++)
            if (!found && m_flag[i] && m_en[i] && !m_pri[i] && m_ghi && m_glo && !m_shi) begin
              found = 1; who = i;
            end
        end
      end
      take = ack_i && m_irq;
      if (take) begin
        if (m_high) begin m_ghi = 0; m_shi = 1; end
        else begin m_glo = 0; m_slo = 1; end
      end else if (rfi_i) begin
        if (m_shi) begin m_shi = 0; m_ghi = 1; end
        else if (m_slo) begin m_slo = 0; m_glo = 1; end
      end
      if (gen_we_i) begin m_ghi = gen_wdata_i[0]; m_glo = gen_wdata_i[1]; end
      if (mode_we_i) m_mode = mode_wdata_i;
      for (int i = 0; i < N; i++) begin
        m_flag[i] = (m_flag[i] && !flag_clr_i[i]) || m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = evt_i[i];
        if (en_we_i) m_en[i] = en_wdata_i[i];
        if (pri_we_i) m_pri[i] = pri_wdata_i[i];
      end
      m_irq  = found && !take;
      m_high = lvl;
      m_src  = who;
      m_vec  = lvl ? 16'h0008 : 16'h0018;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int mf;
      mf = 0;
      for (int i = 0; i < N; i++) if (m_flag[i]) mf |= (1 << i);
      chk(irq_o == m_irq, "R3 model irq", irq_o, m_irq);
      chk(int'(flag_o) == mf, "R6 model flags", flag_o, mf);
      chk(gen_o == {m_glo, m_ghi}, "R7 model global enables", gen_o, {m_glo, m_ghi});
      chk(insvc_o == {m_slo, m_shi}, "R8 model in-service", insvc_o, {m_slo, m_shi});
      chk(mode_o == m_mode, "R2 model mode", mode_o, m_mode);
      if (m_irq) begin
        chk(irq_high_o == m_high, "R1 model level", irq_high_o, m_high);
        chk(int'(irq_vec_o) == m_vec, "R1 model vector", irq_vec_o, m_vec);
        chk(int'(irq_src_o) == m_src, "R11 model source", irq_src_o, m_src);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic fire(input logic [N-1:0] m);
    evt_i = m; @(negedge clk); evt_i = '0;
  endtask
  task automatic clr(input logic [N-1:0] m);
    flag_clr_i = m; @(negedge clk); flag_clr_i = '0;
  endtask
  task automatic wr_en(input logic [N-1:0] v);
    en_we_i = 1; en_wdata_i = v; @(negedge clk); en_we_i = 0;
  endtask
  task automatic wr_pri(input logic [N-1:0] v);
    pri_we_i = 1; pri_wdata_i = v; @(negedge clk); pri_we_i = 0;
  endtask
  task automatic wr_gen(input logic [1:0] v);
    gen_we_i = 1; gen_wdata_i = v; @(negedge clk); gen_we_i = 0;
  endtask
  task automatic wr_mode(input logic v);
    mode_we_i = 1; mode_wdata_i = v; @(negedge clk); mode_we_i = 0;
  endtask
  task automatic do_ack();
    ack_i = 1; @(negedge clk); ack_i = 0;
  endtask
  task automatic do_rfi();
    rfi_i = 1; @(negedge clk); rfi_i = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R2: reset state
    chk(irq_o == 0 && flag_o == 0 && gen_o == 0 && mode_o == 0 && insvc_o == 0,
        "R2 reset state", {irq_o, flag_o, gen_o, mode_o, insvc_o}, 0);

    // legacy mode gating
    wr_en('1);
    wr_gen(2'b01);
    fire(8'h20); cyc(6);
    chk(flag_o[5] == 1, "R6 flag set while gated", flag_o[5], 1);
    chk(irq_o == 0, "R3 peripheral gated by bit 1", irq_o, 0);
    wr_gen(2'b11); cyc(2);
    chk(irq_o == 1 && irq_vec_o == 16'h0008, "R1 legacy vector", irq_vec_o, 16'h0008);
    chk(irq_src_o == 5, "R11 source index", irq_src_o, 5);
    do_ack();
    chk(gen_o == 2'b10 && insvc_o == 2'b01 && irq_o == 0, "R7 legacy take",
        {gen_o, insvc_o, irq_o}, 5'b10010);
    do_rfi();
    chk(gen_o == 2'b11 && insvc_o == 2'b00, "R8 legacy return", {gen_o, insvc_o}, 4'b1100);
    clr(8'h20); cyc(2);

    // R10: event to request timing
    fire(8'h02); cyc(2);
    chk(irq_o == 0, "R10 request not before edge k+3", irq_o, 0);
    cyc(1);
    chk(irq_o == 1 && irq_src_o == 1, "R10 request at edge k+3", {irq_o, irq_src_o}, 4'b1001);
    wr_gen(2'b01); cyc(2);
    chk(irq_o == 1 && irq_src_o == 1, "R3 core source needs only bit 0", irq_o, 1);
    clr('1); cyc(2);

    // priority mode nesting
    wr_mode(1'b1);
    wr_pri(8'h40);
    wr_gen(2'b11);
    fire(8'h0C); cyc(5);
    chk(irq_o == 1 && irq_high_o == 0 && irq_vec_o == 16'h0018, "R1 low vector",
        irq_vec_o, 16'h0018);
    chk(irq_src_o == 2, "R11 lowest low source", irq_src_o, 2);
    do_ack();
    chk(gen_o == 2'b01 && insvc_o == 2'b10, "R7 low take", {gen_o, insvc_o}, 4'b0110);
    fire(8'h40); cyc(5);
    chk(irq_o == 1 && irq_high_o == 1 && irq_vec_o == 16'h0008 && irq_src_o == 6,
        "R9 high preempts low", {irq_o, irq_high_o, irq_src_o}, 5'b11110);
    do_ack();
    chk(gen_o == 2'b00 && insvc_o == 2'b11, "R7 high take", {gen_o, insvc_o}, 4'b0011);
    clr(8'h40);
    do_rfi();
    chk(gen_o == 2'b01 && insvc_o == 2'b10, "R8 high ends first", {gen_o, insvc_o}, 4'b0110);
    cyc(2);
    chk(irq_o == 0, "R5 low pending held by bit 1", irq_o, 0);
    do_rfi();
    chk(gen_o == 2'b11 && insvc_o == 2'b00, "R8 low ends next", {gen_o, insvc_o}, 4'b1100);
    cyc(2);
    chk(irq_o == 1 && irq_high_o == 0 && irq_src_o == 2, "R5 low returns",
        {irq_o, irq_high_o, irq_src_o}, 5'b10010);

    // low request during high handler stays silent
    do_ack();
    clr(8'h0C);
    fire(8'h40); cyc(5);
    do_ack();
    clr(8'h40);
    wr_gen(2'b11);
    fire(8'h04); cyc(5);
    chk(irq_o == 0, "R5 low silent under high", irq_o, 1'b0);
    chk(flag_o[2] == 1, "R6 flag set under high", flag_o[2], 1);
    do_rfi(); do_rfi();
    clr('1); cyc(2);

    // R4: high enable alone
    wr_gen(2'b01);
    fire(8'h44); cyc(5);
    chk(irq_o == 1 && irq_high_o == 1 && irq_src_o == 6, "R4 high with bit 0",
        {irq_o, irq_src_o}, 4'b1110);
    clr(8'h40); cyc(2);
    chk(irq_o == 0, "R5 low needs bit 1", irq_o, 0);
    wr_gen(2'b10); cyc(2);
    chk(irq_o == 0, "R4 bit 0 clear blocks all", irq_o, 0);
    clr('1); cyc(2);

    // legacy mode ignores priority bits
    wr_mode(1'b0);
    wr_gen(2'b11);
    fire(8'h40); cyc(5);
    chk(irq_o == 1 && irq_high_o == 1 && irq_vec_o == 16'h0008, "R1 legacy ignores priority",
        irq_vec_o, 16'h0008);
    fire(8'h01); cyc(5);
    chk(irq_src_o == 0, "R11 lowest source wins", irq_src_o, 0);
    clr('1); cyc(2);

    // R6: event and clear together
    fire(8'h10);
    cyc(1);
    flag_clr_i = 8'h10; @(negedge clk); flag_clr_i = '0;
    chk(flag_o[4] == 1, "R6 event beats clear", flag_o[4], 1);
    clr(8'h10);
    chk(flag_o[4] == 0, "R6 clear strobe", flag_o[4], 0);
    cyc(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule